// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets synchronous logic use a 32K x 8 asynchronous static RAM that has a shared data bus. The user side presents a single request with a read/write flag, a 15-bit address and a write byte. The controller then runs one complete memory cycle. A read returns its byte together with a one-clock done pulse. A write also signals completion with a one-clock done pulse.

On the memory side the controller drives three active-low strobes: select, output enable and write enable. It also drives the address and a data bus split into an output value, an output enable and an input value. Every phase length is a whole number of clock cycles, and each is computed at elaboration by a ceiling divide of a timing minimum by the clock period parameter. This lets the same code meet the memory's access, pulse-width and bus-release windows at any clock rate.

A power-down input parks the memory in a low-power retention state with select held inactive. When power-down is removed, the controller waits out a long recovery lockout before it accepts any new access.

Top module: `sram_ctl`

## Requirements
- R1: While reset is applied and just after it is released, the strobes are inactive (mem_cs_n, mem_oe_n and mem_we_n all 1), mem_dq_oe is 0, and busy and done are 0.
- R2: A read request accepted in idle drives mem_cs_n=0, mem_oe_n=0 and mem_we_n=1 for RD = max(ceil(T_AA/T), ceil(T_OE/T)) cycles, with mem_addr holding the requested address throughout.
- R3: The read byte is captured on the final cycle of the read access. It appears on rdata in the cycle after that, together with a one-cycle done while the strobes are inactive.
- R4: After a read's done cycle, the controller stays busy for TURN = ceil(T_HZ/T) further cycles with all strobes inactive and the data bus not driven. Only then does it return to idle.
- R5: A write request accepted in idle first spends one setup cycle with mem_cs_n=0, mem_we_n=1 and mem_oe_n=1. In that cycle the write byte is already driven (mem_dq_oe=1) and the address is valid.
- R6: mem_we_n is then 0 for WP = max(ceil(T_WP/T), ceil(T_CW/T)-1, ceil(T_DW/T)-1, ceil(T_WC/T)-2) cycles, with select low and data driven.
- R7: After mem_we_n rises, one more cycle keeps select low and the data driven, and raises done. The write therefore occupies WP+2 cycles, and the controller is idle in the cycle after.
- R8: mem_dq_oe is never 1 while mem_oe_n is 0, and it is only 1 while mem_cs_n is 0.
- R9: A request presented while busy is ignored; no access is queued from it.
- R10: pd_req sampled high in idle enters retention: busy is 1 and all strobes are inactive while pd_req stays high, and requests are ignored.
- R11: When pd_req is sampled low in retention, the controller stays busy with strobes inactive for REC = ceil(T_REC/T) cycles and ignores requests, then returns to idle.
- R12: If pd_req and req are both high in the same idle cycle, retention is entered and the request is dropped.
- R13: done is never high for two consecutive cycles, and busy is 0 only when the controller is idle with all strobes inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, sampled in idle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 15 | Access address |
| wdata | input | 8 | Byte to write |
| pd_req | input | 1 | Power-down (retention) request, level |
| rdata | output | 8 | Last byte read |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | High in every non-idle state |
| mem_addr | output | 15 | Memory address |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_o | output | 8 | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | Controller drives the data bus when 1 |
| mem_dq_i | input | 8 | Byte read from the data bus |

## Verification
The assertions assume an orderly user: request fields are held while req is high, and the memory bus returns a value every cycle. They also assume reset is applied from time zero. The stimulus changes inputs only just after the falling edge and keeps every field defined. It holds req for a single cycle except in the deliberate busy-time request tests, and it toggles pd_req only as a clean level. The memory model drives a fixed filler byte whenever a read is not enabled, so a capture taken at the wrong time shows up as a wrong rdata.

// File: rtl/sram_ctl.sv
module sram_ctl #(
  parameter int CLK_NS    = 5,
  parameter int T_AA_NS   = 70,
  parameter int T_OE_NS   = 35,
  parameter int T_RC_NS   = 70,
  parameter int T_HZ_NS   = 30,
  parameter int T_WC_NS   = 70,
  parameter int T_WP_NS   = 55,
  parameter int T_CW_NS   = 60,
  parameter int T_DW_NS   = 30,
  parameter int T_REC_NS  = 5_000_000,
  parameter int AW        = 15,
  parameter int DW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          pd_req,
  output logic [DW-1:0] rdata,
  output logic          done,
  output logic          busy,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);
  function automatic int cdiv(int t);
    return (t + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int TURN_C = mx(1, cdiv(T_HZ_NS));
  localparam int RD_C   = mx(1, mx(mx(cdiv(T_AA_NS), cdiv(T_OE_NS)), cdiv(T_RC_NS) - 1 - TURN_C));
  localparam int WP_C   = mx(1, mx(mx(cdiv(T_WP_NS), cdiv(T_CW_NS) - 1),
                                   mx(cdiv(T_DW_NS) - 1, cdiv(T_WC_NS) - 2)));
  localparam int REC_C  = mx(1, cdiv(T_REC_NS));
  localparam int CW     = $clog2(mx(REC_C, mx(RD_C, mx(TURN_C, WP_C))) + 1);

  typedef enum logic [3:0] {
    IDLE, READ_ADDR, READ_SAMPLE, READ_TURN,
    WRITE_SETUP, WRITE_PULSE, WRITE_END, RETENTION, RECOVER
  } state_t;

  state_t          state;
  logic [CW-1:0]   cnt;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic            last;

  assign last = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata   <= '0;
    end else begin
      case (state)
        IDLE:
          if (pd_req) state <= RETENTION;
          else if (req) begin
            addr_q  <= addr;
            wdata_q <= wdata;
            if (wr) state <= WRITE_SETUP;
            else begin
              state <= READ_ADDR;
              cnt   <= CW'(RD_C - 1);
            end
          end
        READ_ADDR:
          if (last) begin
            rdata <= mem_dq_i;
            state <= READ_SAMPLE;
          end else cnt <= cnt - 1'b1;
        READ_SAMPLE: begin
          state <= READ_TURN;
          cnt   <= CW'(TURN_C - 1);
        end
        READ_TURN:
          if (last) state <= IDLE;
          else cnt <= cnt - 1'b1;
        WRITE_SETUP: begin
          state <= WRITE_PULSE;
          cnt   <= CW'(WP_C - 1);
        end
        WRITE_PULSE:
          if (last) state <= WRITE_END;
          else cnt <= cnt - 1'b1;
        WRITE_END: state <= IDLE;
        RETENTION:
          if (!pd_req) begin
            state <= RECOVER;
            cnt   <= CW'(REC_C - 1);
          end
        RECOVER:
          if (last) state <= IDLE;
          else cnt <= cnt - 1'b1;
        default: state <= IDLE;
      endcase
    end
  end

  assign mem_cs_n  = !(state inside {READ_ADDR, WRITE_SETUP, WRITE_PULSE, WRITE_END});
  assign mem_oe_n  = (state != READ_ADDR);
  assign mem_we_n  = (state != WRITE_PULSE);
  assign mem_dq_oe = (state inside {WRITE_SETUP, WRITE_PULSE, WRITE_END});
  assign done      = (state inside {READ_SAMPLE, WRITE_END});
  assign busy      = (state != IDLE);
  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int AW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pd_req,
  input logic          done,
  input logic          busy,
  input logic [AW-1:0] mem_addr,
  input logic          mem_cs_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_dq_oe
);
  assert_no_bus_fight_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && !mem_cs_n));

  assert_we_with_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_dq_oe && mem_oe_n));

  assert_data_held_at_we_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_cs_n && done));

  assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  assert_done_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !done));

  assert_enter_retention_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_req && !busy) |=> (busy && mem_cs_n));
endmodule

bind sram_ctl sram_ctl_chk #(.AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .done(done), .busy(busy),
  .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_ctl_test.sv
module sram_ctl_test;
  // 200 MHz clock, recovery shortened to 200 ns for the bench
  localparam int RD_N   = 14; // ceil(70/5)
  localparam int TURN_N = 6;  // ceil(30/5)
  localparam int WP_N   = 12; // max(11, 12-1, 6-1, 14-2)
  localparam int REC_N  = 40; // ceil(200/5)

  logic clk = 0, rst_n = 0;
  logic req = 0, wr = 0, pd_req = 0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata, mem_dq_o, mem_dq_i;
  logic [14:0] mem_addr;
  logic done, busy, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  int tests = 0, fails = 0;
  bit finished = 0;
  string scen = "R1 reset";

  always #2.5 clk = ~clk;

  sram_ctl #(.T_REC_NS(200)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .pd_req(pd_req), .rdata(rdata), .done(done), .busy(busy), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // behavioural memory
  logic [7:0] mem [int];
  function automatic logic [7:0] rd_mem(int a);
    logic [7:0] fill = 8'(a) ^ 8'h5A;
    return mem.exists(a) ? mem[a] : fill;
  endfunction
  assign mem_dq_i = (!mem_cs_n && !mem_oe_n && mem_we_n) ? rd_mem(int'(mem_addr)) : 8'hEE;
  always @(negedge clk)
    if (!mem_cs_n && !mem_we_n && mem_dq_oe) mem[int'(mem_addr)] = mem_dq_o;

  // reference model: a queue of expected cycles built at acceptance
  typedef struct {
    bit cs, oe, we, dq, dn, bz, rd;
    logic [14:0] a;
    logic [7:0]  d;
    string tag;
  } exp_t;
  exp_t q[$];
  exp_t cur;
  bit ret = 0;

  function automatic exp_t mk(bit cs, bit oe, bit we, bit dq, bit dn, bit bz, string tag);
    exp_t e;
    e.cs = cs; e.oe = oe; e.we = we; e.dq = dq; e.dn = dn; e.bz = bz;
    e.rd = 0; e.a = '0; e.d = '0; e.tag = tag;
    return e;
  endfunction

  initial cur = mk(1, 1, 1, 0, 0, 0, "R1");

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); ret = 0; cur = mk(1, 1, 1, 0, 0, 0, "R1");
    end else if (q.size() > 0) cur = q.pop_front();
    else if (ret) begin
      if (pd_req) cur = mk(1, 1, 1, 0, 0, 1, "R10");
      else begin
        ret = 0;
        for (int i = 1; i < REC_N; i++) q.push_back(mk(1, 1, 1, 0, 0, 1, "R11"));
        cur = mk(1, 1, 1, 0, 0, 1, "R11");
      end
    end else if (pd_req) begin
      ret = 1; cur = mk(1, 1, 1, 0, 0, 1, "R10");
    end else if (req) begin
      exp_t e;
      if (wr) begin
        e = mk(0, 1, 1, 1, 0, 1, "R5"); e.a = addr; e.d = wdata; q.push_back(e);
        for (int i = 0; i < WP_N; i++) begin
          e = mk(0, 1, 0, 1, 0, 1, "R6"); e.a = addr; e.d = wdata; q.push_back(e);
        end
        e = mk(0, 1, 1, 1, 1, 1, "R7"); e.a = addr; e.d = wdata; q.push_back(e);
      end else begin
        for (int i = 0; i < RD_N; i++) begin
          e = mk(0, 0, 1, 0, 0, 1, "R2"); e.a = addr; q.push_back(e);
        end
        e = mk(1, 1, 1, 0, 1, 1, "R3"); e.rd = 1; e.d = rd_mem(int'(addr)); q.push_back(e);
        for (int i = 0; i < TURN_N; i++) q.push_back(mk(1, 1, 1, 0, 0, 1, "R4"));
      end
      cur = q.pop_front();
    end else cur = mk(1, 1, 1, 0, 0, 0, "R13");
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) if (!finished) begin
    tests++;
    if ({mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, done, busy} !==
        {cur.cs, cur.oe, cur.we, cur.dq, cur.dn, cur.bz}) begin
      fails++;
      $display("FAIL %s [%s] cs/oe/we/dqoe/done/busy=%b expected %b", cur.tag, scen,
               {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, done, busy},
               {cur.cs, cur.oe, cur.we, cur.dq, cur.dn, cur.bz});
    end
    if (!cur.cs) begin
      tests++;
      if (mem_addr !== cur.a) begin
        fails++;
        $display("FAIL %s [%s] mem_addr=%h expected %h", cur.tag, scen, mem_addr, cur.a);
      end
    end
    if (cur.dq) begin
      tests++;
      if (mem_dq_o !== cur.d) begin
        fails++;
        $display("FAIL %s [%s] mem_dq_o=%h expected %h", cur.tag, scen, mem_dq_o, cur.d);
      end
    end
    if (cur.rd) begin
      tests++;
      if (rdata !== cur.d) begin
        fails++;
        $display("FAIL R3 [%s] rdata=%h expected %h", scen, rdata, cur.d);
      end
    end
    if (mem_dq_oe && !mem_oe_n) begin
      fails++;
      $display("FAIL R8 [%s] dq_oe=1 oe_n=0 expected oe_n=1", scen);
    end
  end

  task automatic access(bit w, logic [14:0] a, logic [7:0] d);
    wr = w; addr = a; wdata = d; req = 1;
    @(negedge clk); #1 req = 0;
    while (busy) @(negedge clk);
    #1;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    idle(4);
    rst_n = 1;
    idle(3);
    scen = "R5 R6 R7 write"; access(1, 15'h1234, 8'hA5);
    scen = "R2 R3 readback"; access(0, 15'h1234, 8'h00);
    scen = "R2 R3 untouched top"; access(0, 15'h7FFF, 8'h00);
    scen = "R7 back-to-back"; access(1, 15'h0000, 8'h3C);
    access(0, 15'h0000, 8'h00);
    access(1, 15'h4001, 8'hFF);
    access(1, 15'h4001, 8'h00);
    access(0, 15'h4001, 8'h00);
    // R9: write requests held during a read must be dropped
    scen = "R9 busy requests";
    wr = 0; addr = 15'h0100; req = 1;
    @(negedge clk); #1 wr = 1; wdata = 8'h77;
    idle(10);
    req = 0;
    while (busy) @(negedge clk);
    #1;
    access(0, 15'h0100, 8'h00);
    // R10 R11: retention with requests during retention and recovery
    scen = "R10 retention";
    pd_req = 1;
    idle(5);
    wr = 1; addr = 15'h0200; wdata = 8'h11; req = 1;
    idle(20);
    req = 0; pd_req = 0;
    scen = "R11 recovery";
    idle(10);
    req = 1;
    idle(3);
    req = 0;
    while (busy) @(negedge clk);
    #1;
    access(0, 15'h0200, 8'h00);
    // R12: same-cycle power-down and request
    scen = "R12 priority";
    wr = 1; addr = 15'h0300; wdata = 8'h99; req = 1; pd_req = 1;
    @(negedge clk); #1 req = 0;
    idle(4);
    pd_req = 0;
    while (busy) @(negedge clk);
    #1;
    access(0, 15'h0300, 8'h00);
    scen = "R13 idle";
    idle(5);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule